// File: doc/BRIEF.md
# System Clock Source Controller

This block chooses where the system clock comes from, either the main oscillator or a PLL, and divides that source by a programmable ratio from 1 to 16. It works in a single core clock domain. Each source reaches it as a one-cycle tick input, and the divided system clock leaves it as a one-cycle clock-enable pulse, `sys_ce`. A byte-wide control register holds these fields:

- the fast-source select
- the PLL power-down request
- the slow-clock select
- two auxiliary clock enables
- a power-on status flag

A second register holds the division ratio. Software writes and reads both registers over a minimal register bus.

Some control bits depend on each other, and writes that would break those dependencies are ignored:

- The system clock cannot move to the PLL while the PLL is powered down or not yet stable.
- The PLL cannot be powered down while it is still selected, or while it is still the applied source.

A change of source or of ratio is held back until the divider reaches its terminal count. This keeps every output period whole.

Top module: `sysclk_src_ctl`

## Requirements
- R1: After reset the control register reads 0x06 (main source selected, PLL powered down, all other bits 0), the ratio register reads 0x00, `pll_stop` is 1, and `src_pll` and `sys_ce` are 0.
- R2: A control write with bit 1 (fast select, 1 = main, 0 = PLL) equal to 0 leaves bit 1 unchanged when, before that write, bit 2 (PLL power-down) is 1 or `pll_stable` is 0.
- R3: A control write with bit 2 equal to 1 leaves bit 2 unchanged when, before that write, bit 1 is 0 or the applied source (`src_pll`) is the PLL.
- R4: `pll_stop` follows control bit 2. The PLL is never stopped while it is the applied source.
- R5: Control bits 7:6 and ratio register bits 7:4 read as zero and ignore writes.
- R6: Control bit 5 (power-on status) is set by a `por_event` pulse and cleared by writing 1 to bit 5. A set and a clear in the same cycle leave the bit set.
- R7: With ratio field N (ratio N+1) in force, `sys_ce` pulses once for every N+1 ticks of the applied source, on the last tick of each group.
- R8: A newly written ratio takes effect only at the terminal count of the ratio currently in force.
- R9: A change of fast select moves the applied source (`src_pll`) only at a terminal count, in the same cycle as that `sys_ce` pulse.
- R10: `slow_sel`, `aux1_en` and `aux2_en` follow control bits 0, 3 and 4.
- R11: Only ticks of the applied source advance the divider. Ticks on the other source input have no effect on `sys_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 control, 1 ratio |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| main_tick | input | 1 | One-cycle tick from the main oscillator |
| pll_tick | input | 1 | One-cycle tick from the PLL |
| pll_stable | input | 1 | PLL output has settled |
| por_event | input | 1 | Power-on detection pulse |
| pll_stop | output | 1 | Request to power down the PLL |
| sys_ce | output | 1 | Divided system clock enable |
| src_pll | output | 1 | Applied source is the PLL |
| slow_sel | output | 1 | Slow clock from the 32.768 kHz oscillator |
| aux1_en | output | 1 | Auxiliary clock 1 enable |
| aux2_en | output | 1 | Auxiliary clock 2 enable |

## Verification
On every cycle the assertions check the interlocks:

- The fast select only falls when the PLL is powered and stable.
- The PLL is never stopped while it is applied.
- The applied source and the ratio in force only change together with a `sys_ce` pulse.
- Each pulse follows a tick of the source that was applied at the time.

Only the bench scenarios can show the exact spacing of pulses for ratios 1, 3 and 16, the stretch of a group when the ratio is changed mid-count, and the read-back values after refused writes. The same applies to the set-wins rule on the power-on flag.

// File: rtl/sysclk_src_ctl.sv
module sysclk_src_ctl #(
  parameter int DIV_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       main_tick,
  input  logic       pll_tick,
  input  logic       pll_stable,
  input  logic       por_event,
  output logic       pll_stop,
  output logic       sys_ce,
  output logic       src_pll,
  output logic       slow_sel,
  output logic       aux1_en,
  output logic       aux2_en
);
  localparam int PAD = 8 - DIV_W;

  logic             fclk_q, pllpwd_q, sclk_q, aux1_q, aux2_q, por_q;
  logic [DIV_W-1:0] div_q, div_act_q, cnt_q;
  logic             src_q, ce_q;

  logic ctl_wr, div_wr, fclk_block, pwd_block, src_tick, at_tc;

  assign ctl_wr     = reg_wr & ~reg_sel;
  assign div_wr     = reg_wr &  reg_sel;
  assign fclk_block = ~reg_wdata[1] & (pllpwd_q | ~pll_stable);
  assign pwd_block  =  reg_wdata[2] & (~fclk_q | src_q);
  assign src_tick   = src_q ? pll_tick : main_tick;
  assign at_tc      = src_tick & (cnt_q == div_act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_q   <= 1'b1;
      pllpwd_q <= 1'b1;
      sclk_q   <= 1'b0;
      aux1_q   <= 1'b0;
      aux2_q   <= 1'b0;
    end else if (ctl_wr) begin
      sclk_q <= reg_wdata[0];
      aux1_q <= reg_wdata[3];
      aux2_q <= reg_wdata[4];
      if (!fclk_block) fclk_q   <= reg_wdata[1];
      if (!pwd_block)  pllpwd_q <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    por_q <= 1'b0;
    else if (por_event)            por_q <= 1'b1;
    else if (ctl_wr && reg_wdata[5]) por_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_wr) div_q <= reg_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      div_act_q <= '0;
      src_q     <= 1'b0;
      ce_q      <= 1'b0;
    end else begin
      ce_q <= at_tc;
      if (at_tc) begin
        cnt_q     <= '0;
        div_act_q <= div_q;
        src_q     <= ~fclk_q;
      end else if (src_tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign reg_rdata = reg_sel ? {{PAD{1'b0}}, div_q}
                             : {2'b00, por_q, aux2_q, aux1_q, pllpwd_q, fclk_q, sclk_q};
  assign pll_stop  = pllpwd_q;
  assign sys_ce    = ce_q;
  assign src_pll   = src_q;
  assign slow_sel  = sclk_q;
  assign aux1_en   = aux1_q;
  assign aux2_en   = aux2_q;
endmodule

// File: rtl/sysclk_src_ctl_chk.sv
module sysclk_src_ctl_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             main_tick,
  input logic             pll_tick,
  input logic             pll_stable,
  input logic             pll_stop,
  input logic             sys_ce,
  input logic             src_pll,
  input logic             fclk_q,
  input logic             pllpwd_q,
  input logic [DIV_W-1:0] div_act_q
);
  // R2
  fclk_clear_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fclk_q) |-> ($past(pll_stable) && !$past(pllpwd_q)));

  // R4
  pll_kept_while_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pll |-> !pll_stop);

  // R4
  stop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_stop) |-> $past(reg_wr && !reg_sel && reg_wdata[2]));

  // R9
  switch_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_pll) |-> sys_ce);

  // R8
  ratio_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_act_q) |-> sys_ce);

  // R11
  ce_from_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce |-> ($past(src_pll) ? $past(pll_tick) : $past(main_tick)));

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[7:6] == 2'b00));
endmodule

bind sysclk_src_ctl sysclk_src_ctl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .main_tick(main_tick),
  .pll_tick(pll_tick), .pll_stable(pll_stable), .pll_stop(pll_stop),
  .sys_ce(sys_ce), .src_pll(src_pll), .fclk_q(fclk_q),
  .pllpwd_q(pllpwd_q), .div_act_q(div_act_q)
);

// File: tb/sim_sysclk_src_ctl.sv
`timescale 1ns/1ps
module sim_sysclk_src_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic main_tick = 1'b0, pll_tick = 1'b0, pll_stable = 1'b0, por_event = 1'b0;
  logic pll_stop, sys_ce, src_pll, slow_sel, aux1_en, aux2_en;

  int tests = 0, fails = 0;
  logic [7:0] v;
  logic ce;

  // {pll_stable, write data, expected control read-back}
  localparam logic [16:0] VEC [0:6] = '{
    {1'b0, 8'h04, 8'h06},
    {1'b0, 8'h00, 8'h02},
    {1'b0, 8'h00, 8'h02},
    {1'b1, 8'hC0, 8'h00},
    {1'b1, 8'h04, 8'h00},
    {1'b1, 8'h1F, 8'h1B},
    {1'b1, 8'h06, 8'h06}
  };

  sysclk_src_ctl u0 (.*);

  always #2 clk = ~clk;

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_sel = a; #1 d = reg_rdata;
  endtask

  task automatic tk(input logic m, input logic p, output logic c);
    @(negedge clk); main_tick = m; pll_tick = p;
    @(negedge clk); main_tick = 1'b0; pll_tick = 1'b0; c = sys_ce;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(0, v); chk("R1 ctrl", v, 8'h06);
    rd(1, v); chk("R1 ratio", v, 8'h00);
    chk("R1 outputs", {2'b0, pll_stop, src_pll, sys_ce, slow_sel, aux1_en, aux2_en}, 8'h20);

    // R2 R3 R5: interlock table
    for (int i = 0; i < 7; i++) begin
      pll_stable = VEC[i][16];
      wr(0, VEC[i][15:8]);
      rd(0, v);
      chk($sformatf("R2 R3 R5 table %0d", i), v, VEC[i][7:0]);
    end

    // R5 ratio register, R7 ratio 3
    wr(1, 8'hF2); rd(1, v); chk("R5 ratio upper bits", v, 8'h02);
    tk(1, 0, ce); chk("R7 load tick", ce, 1'b1);
    for (int k = 0; k < 6; k++) begin
      tk(1, 0, ce); chk($sformatf("R7 ratio3 tick %0d", k), ce, (k % 3 == 2));
    end
    // R8 mid-count change
    tk(1, 0, ce); chk("R8 count1", ce, 1'b0);
    wr(1, 8'h00);
    tk(1, 0, ce); chk("R8 old ratio kept", ce, 1'b0);
    tk(1, 0, ce); chk("R8 terminal", ce, 1'b1);
    tk(1, 0, ce); chk("R8 new ratio", ce, 1'b1);

    // R9 R11 R3 R4 source switching
    wr(0, 8'h02); rd(0, v); chk("R4 pll on", v, 8'h02);
    chk("R4 stop low", pll_stop, 1'b0);
    wr(0, 8'h00); rd(0, v); chk("R2 select pll", v, 8'h00);
    chk("R9 pending", src_pll, 1'b0);
    tk(0, 1, ce); chk("R11 pll ignored", ce, 1'b0);
    chk("R9 still main", src_pll, 1'b0);
    tk(1, 0, ce); chk("R9 boundary pulse", ce, 1'b1);
    chk("R9 switched", src_pll, 1'b1);
    tk(1, 0, ce); chk("R11 main ignored", ce, 1'b0);
    tk(0, 1, ce); chk("R11 pll counts", ce, 1'b1);
    wr(0, 8'h06); rd(0, v); chk("R3 pwd refused while applied", v, 8'h02);
    chk("R4 stop stays low", pll_stop, 1'b0);
    tk(0, 1, ce); chk("R9 back pulse", ce, 1'b1);
    chk("R9 back to main", src_pll, 1'b0);
    wr(0, 8'h06); rd(0, v); chk("R3 pwd accepted", v, 8'h06);
    chk("R4 stop high", pll_stop, 1'b1);

    // R10
    wr(0, 8'h1F);
    chk("R10 outputs set", {5'b0, slow_sel, aux1_en, aux2_en}, 8'h07);
    wr(0, 8'h06);
    chk("R10 outputs clear", {5'b0, slow_sel, aux1_en, aux2_en}, 8'h00);

    // R6
    @(negedge clk); por_event = 1'b1; @(negedge clk); por_event = 1'b0;
    rd(0, v); chk("R6 set", v, 8'h26);
    wr(0, 8'h06); rd(0, v); chk("R6 write 0 keeps", v, 8'h26);
    @(negedge clk); reg_sel = 1'b0; reg_wdata = 8'h26; reg_wr = 1'b1; por_event = 1'b1;
    @(negedge clk); reg_wr = 1'b0; por_event = 1'b0;
    rd(0, v); chk("R6 set wins", v, 8'h26);
    wr(0, 8'h26); rd(0, v); chk("R6 clear", v, 8'h06);

    // R7 ratio 16
    wr(1, 8'h0F);
    tk(1, 0, ce); chk("R7 load 16", ce, 1'b1);
    for (int k = 0; k < 16; k++) begin
      tk(1, 0, ce); chk($sformatf("R7 ratio16 tick %0d", k), ce, (k == 15));
    end

    finish_run();
  end
endmodule